// File: doc/BRIEF.md
# Segmented memory access permission checker

This block watches every bus access and compares it against read, write and execute permissions held separately for four address regions: three main-memory segments whose split points come in as programmable boundary inputs, and one fixed information window. A 16-bit permission register, written through a small configuration port, holds four nibbles, one per region. Each nibble carries that region's three access enables and a response-select bit.

An access that breaks its region's permissions sets a sticky per-region violation flag. The response-select bit of the region decides what follows. When it is clear, the flag raises a non-maskable interrupt request, provided the global interrupt enable is high. When it is set, the block sends a one-cycle reset request. On the cycle after that request, the block puts its own register and flags back to their reset values. Software clears flags by writing ones to the flag-clear address of the configuration port.

Top module: `seg_perm_checker`

## Requirements
- R1: After reset, perm_o reads 16'h7777 (every enable 1, every select bit 0), viol_flags_o is 0, and nmi_req_o and rst_req_o are low.
- R2: Region decode, with flag bit index in brackets. Info window INFO_BASE..INFO_LAST [3] takes priority. Within MAIN_BASE..MAIN_LAST, addresses below bnd1_i go to segment 1 [0], addresses from bnd1_i up to below bnd2_i go to segment 2 [1], and the rest go to segment 3 [2]. Any other address never sets a flag.
- R3: The nibble for flag bit k sits at perm bits 4k+3:4k, with bit 0 read enable, bit 1 write enable, bit 2 execute enable and bit 3 response select. A cfg_we_i write with cfg_sel_i=0 loads perm_o on the next edge. A write access (acc_type_i=2'b01) to a region whose write enable is 0 is a violation.
- R4: A fetch (acc_type_i=2'b10) from a region whose execute enable is 0 is a violation.
- R5: A read (acc_type_i=2'b00) is a violation only when the region's read, write and execute enables are all 0.
- R6: A violation sets its region's flag on the next edge. Flags stay set until a cfg_we_i write with cfg_sel_i=1 has a 1 in cfg_wdata_i bit k. If a new violation and a clear reach the same flag in one cycle, the flag stays set.
- R7: nmi_req_o is high whenever nmi_en_i is 1 and some set flag belongs to a region whose select bit is 0.
- R8: A violation in a region whose select bit is 1 drives rst_req_o high for exactly the one cycle after the access.
- R9: On the edge that ends a rst_req_o pulse, perm_o returns to 16'h7777 and the flags return to 0. Configuration writes and accesses presented in that cycle are discarded.
- R10: An access with acc_valid_i low, or with acc_type_i=2'b11, never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: permission register, 1: flag clear (write one) |
| cfg_wdata_i | input | 16 | Configuration write data |
| bnd1_i | input | 16 | Segment 1/2 boundary |
| bnd2_i | input | 16 | Segment 2/3 boundary |
| nmi_en_i | input | 1 | Global violation interrupt enable |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 16 | Access address |
| acc_type_i | input | 2 | 00 read, 01 write, 10 fetch, 11 none |
| perm_o | output | 16 | Current permission register |
| viol_flags_o | output | 4 | Sticky violation flags (seg1, seg2, seg3, info) |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two events can land in the same cycle. In the first, software writes a clear for a flag while a new violation hits that same region. The bench provokes this by issuing the clear and a forbidden write in one cycle, and then expects the flag to read 1 on the next edge. In the second, a configuration write meets a reset request. The bench puts a permission write in the cycle where rst_req_o is high, and then expects perm_o to read 16'h7777 and not the written value.

// File: rtl/seg_perm_pkg.sv
package seg_perm_pkg;
  localparam int unsigned NUM_RGN = 4;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned CFG_W   = NUM_RGN * NIB_W;
  localparam int unsigned BIT_RD  = 0;
  localparam int unsigned BIT_WR  = 1;
  localparam int unsigned BIT_EX  = 2;
  localparam int unsigned BIT_VS  = 3;
  localparam logic [NIB_W-1:0] NIB_RST = 4'h7;
  localparam logic [CFG_W-1:0] PERM_RST = {NUM_RGN{NIB_RST}};

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_NONE  = 2'b11
  } acc_type_e;
endpackage

// File: rtl/seg_rgn_decode.sv
module seg_rgn_decode
  import seg_perm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 'h4000,
  parameter logic [ADDR_W-1:0] MAIN_LAST = 'hFFFF,
  parameter logic [ADDR_W-1:0] INFO_BASE = 'h1800,
  parameter logic [ADDR_W-1:0] INFO_LAST = 'h19FF
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  bnd1_i,
  input  logic [ADDR_W-1:0]  bnd2_i,
  output logic [NUM_RGN-1:0] sel_o
);
  logic in_info, in_main, lo1, lo2;

  always_comb begin
    in_info = (addr_i >= INFO_BASE) && (addr_i <= INFO_LAST);
    in_main = (addr_i >= MAIN_BASE) && (addr_i <= MAIN_LAST) && !in_info;
    lo1     = addr_i < bnd1_i;
    lo2     = addr_i < bnd2_i;
    sel_o[0] = in_main && lo1;
    sel_o[1] = in_main && !lo1 && lo2;
    sel_o[2] = in_main && !lo1 && !lo2;
    sel_o[3] = in_info;
  end
endmodule

// File: rtl/seg_perm_eval.sv
module seg_perm_eval
  import seg_perm_pkg::*;
(
  input  logic             valid_i,
  input  logic             sel_i,
  input  acc_type_e        type_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             viol_o
);
  logic deny;

  always_comb begin
    unique case (type_i)
      // read is refused only when no access right at all is granted
      ACC_READ:  deny = !(nib_i[BIT_RD] || nib_i[BIT_WR] || nib_i[BIT_EX]);
      ACC_WRITE: deny = !nib_i[BIT_WR];
      ACC_FETCH: deny = !nib_i[BIT_EX];
      default:   deny = 1'b0;
    endcase
    viol_o = valid_i && sel_i && deny;
  end
endmodule

// File: rtl/seg_perm_state.sv
module seg_perm_state
  import seg_perm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [NUM_RGN-1:0] hit_i,
  input  logic [NUM_RGN-1:0] vs_i,
  output logic [CFG_W-1:0]   perm_o,
  output logic [NUM_RGN-1:0] flags_o,
  output logic               rst_req_o
);
  logic [CFG_W-1:0]   perm_q;
  logic [NUM_RGN-1:0] flags_q, clr;
  logic               rst_q;

  assign clr = (cfg_we_i && cfg_sel_i) ? cfg_wdata_i[NUM_RGN-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perm_q  <= PERM_RST;
      flags_q <= '0;
      rst_q   <= 1'b0;
    end else if (rst_q) begin
      perm_q  <= PERM_RST;
      flags_q <= '0;
      rst_q   <= 1'b0;
    end else begin
      if (cfg_we_i && !cfg_sel_i) perm_q <= cfg_wdata_i;
      flags_q <= (flags_q & ~clr) | hit_i;
      rst_q   <= |(hit_i & vs_i);
    end
  end

  assign perm_o    = perm_q;
  assign flags_o   = flags_q;
  assign rst_req_o = rst_q;

  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R9
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> (perm_q == PERM_RST && flags_q == '0));
  // R6
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_q |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_q |=> ((flags_q & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/seg_perm_checker.sv
module seg_perm_checker
  import seg_perm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 'h4000,
  parameter logic [ADDR_W-1:0] MAIN_LAST = 'hFFFF,
  parameter logic [ADDR_W-1:0] INFO_BASE = 'h1800,
  parameter logic [ADDR_W-1:0] INFO_LAST = 'h19FF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [ADDR_W-1:0]  bnd1_i,
  input  logic [ADDR_W-1:0]  bnd2_i,
  input  logic               nmi_en_i,
  input  logic               acc_valid_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [1:0]         acc_type_i,
  output logic [CFG_W-1:0]   perm_o,
  output logic [NUM_RGN-1:0] viol_flags_o,
  output logic               nmi_req_o,
  output logic               rst_req_o
);
  logic [NUM_RGN-1:0] sel, hit, vs;
  logic [CFG_W-1:0]   perm;
  logic [NUM_RGN-1:0] flags;
  acc_type_e          acc_type;

  assign acc_type = acc_type_e'(acc_type_i);

  seg_rgn_decode #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .MAIN_LAST(MAIN_LAST),
    .INFO_BASE(INFO_BASE), .INFO_LAST(INFO_LAST)
  ) u_decode (
    .addr_i(acc_addr_i),
    .bnd1_i(bnd1_i),
    .bnd2_i(bnd2_i),
    .sel_o (sel)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [NIB_W-1:0] nib;
    assign nib   = perm[g*NIB_W +: NIB_W];
    assign vs[g] = nib[BIT_VS];

    seg_perm_eval u_eval (
      .valid_i(acc_valid_i),
      .sel_i  (sel[g]),
      .type_i (acc_type),
      .nib_i  (nib),
      .viol_o (hit[g])
    );

    // R5
    read_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_type_i == 2'b00 && (|nib[2:0])) |-> !hit[g]);
  end

  seg_perm_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .hit_i      (hit),
    .vs_i       (vs),
    .perm_o     (perm),
    .flags_o    (flags),
    .rst_req_o  (rst_req_o)
  );

  assign perm_o       = perm;
  assign viol_flags_o = flags;
  assign nmi_req_o    = nmi_en_i && |(flags & ~vs);

  // R2
  rgn_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i || acc_type_i == 2'b11) |-> (hit == '0));
  // R7
  nmi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_en_i |-> !nmi_req_o);
endmodule

// File: tb/seg_perm_checker_tb_top.sv
module seg_perm_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] bnd1 = 16'h8000, bnd2 = 16'hC000;
  logic        nmi_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_type = 2'b11;
  logic [15:0] perm;
  logic [3:0]  flags;
  logic        nmi_req, rst_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_perm = 16'h7777;
  logic [3:0]  m_flags = '0;
  logic        m_rst = 1'b0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  seg_perm_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .bnd1_i(bnd1), .bnd2_i(bnd2), .nmi_en_i(nmi_en),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_type_i(acc_type),
    .perm_o(perm), .viol_flags_o(flags), .nmi_req_o(nmi_req), .rst_req_o(rst_req)
  );

  function automatic int region(input logic [15:0] a);
    if (a >= 16'h1800 && a <= 16'h19FF) return 3;
    if (a < 16'h4000) return -1;
    if (a < bnd1) return 0;
    if (a < bnd2) return 1;
    return 2;
  endfunction

  task automatic compare(input logic [21:0] exp, input string tag);
    logic [21:0] act;
    act = {flags, nmi_req, rst_req, perm};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flags/nmi/rst/perm act=%h_%b_%b_%h exp=%h_%b_%b_%h", tag,
               act[21:18], act[17], act[16], act[15:0], exp[21:18], exp[17], exp[16], exp[15:0]);
    end
  endtask

  // driver: one operation per cycle, model computes post-edge state
  task automatic op(input logic we, input logic sel, input logic [15:0] wd,
                    input logic v, input logic [15:0] a, input logic [1:0] t,
                    input logic en, input string tag);
    int r;
    logic [3:0] nib, hitv, vsv;
    logic deny;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_type = t; nmi_en = en;
    hitv = '0;
    r = region(a);
    if (v && r >= 0) begin
      nib = m_perm[r*4 +: 4];
      case (t)
        2'b00: deny = (nib[2:0] == 3'b000);
        2'b01: deny = !nib[1];
        2'b10: deny = !nib[2];
        default: deny = 1'b0;
      endcase
      hitv[r] = deny;
    end
    for (int k = 0; k < 4; k++) vsv[k] = m_perm[k*4+3];
    if (m_rst) begin
      m_perm = 16'h7777; m_flags = '0; m_rst = 1'b0;
    end else begin
      m_rst = |(hitv & vsv);
      m_flags = (m_flags & ~((we && sel) ? wd[3:0] : 4'h0)) | hitv;
      if (we && !sel) m_perm = wd;
    end
    for (int k = 0; k < 4; k++) vsv[k] = m_perm[k*4+3];
    exp_q.push_back({m_flags, en && |(m_flags & ~vsv), m_rst, m_perm});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic en, input string tag);
    op(1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 2'b11, en, tag);
  endtask

  task automatic acc(input logic [15:0] a, input logic [1:0] t, input logic en, input string tag);
    op(1'b0, 1'b0, 16'h0, 1'b1, a, t, en, tag);
  endtask

  task automatic wperm(input logic [15:0] d, input string tag);
    op(1'b1, 1'b0, d, 1'b0, 16'h0, 2'b11, 1'b1, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    compare({4'h0, 1'b0, 1'b0, 16'h7777}, "R1 reset state");
    @(negedge clk); rst_n = 1'b1;
    idle(1'b1, "R1 idle after reset");
    acc(16'h4000, 2'b00, 1'b1, "R5 read default perms");
    wperm(16'h7770, "R3 perm write seg1 all off");
    acc(16'h5000, 2'b00, 1'b1, "R5 read no rights -> flag, R7 nmi");
    op(1'b1, 1'b1, 16'h0001, 1'b0, 0, 2'b11, 1'b1, "R6 clear seg1");
    wperm(16'h7717, "R3 seg2 read-only");
    acc(16'h9000, 2'b01, 1'b1, "R3 write to seg2 denied");
    acc(16'h9000, 2'b00, 1'b1, "R5 read seg2 allowed");
    op(1'b1, 1'b1, 16'h0002, 1'b0, 0, 2'b11, 1'b0, "R6 clear seg2");
    wperm(16'h7347, "R4 seg3 no exec, seg2 exec-only");
    acc(16'hC000, 2'b10, 1'b0, "R4 fetch seg3 denied, R7 nmi off");
    idle(1'b1, "R7 nmi follows enable");
    acc(16'h9000, 2'b00, 1'b1, "R5 read exec-only seg2 allowed");
    acc(16'hC000, 2'b01, 1'b1, "R3 write seg3 allowed");
    op(1'b1, 1'b1, 16'h000F, 1'b0, 0, 2'b11, 1'b1, "R6 clear all");
    op(1'b0, 1'b0, 0, 1'b0, 16'hC000, 2'b10, 1'b1, "R10 invalid fetch ignored");
    acc(16'hC000, 2'b11, 1'b1, "R10 type none ignored");
    wperm(16'h5000, "R3 all main off, info no write");
    acc(16'h2000, 2'b01, 1'b1, "R2 outside regions unchecked");
    acc(16'h1800, 2'b01, 1'b1, "R2 info write denied flag bit3");
    acc(16'h3FFF, 2'b00, 1'b1, "R2 below main unchecked");
    op(1'b1, 1'b1, 16'h0008, 1'b0, 0, 2'b11, 1'b1, "R6 clear info");
    acc(16'h7FFF, 2'b00, 1'b1, "R2 boundary seg1 top");
    acc(16'h8000, 2'b10, 1'b1, "R2 boundary seg2 bottom");
    acc(16'hFFFF, 2'b01, 1'b1, "R2 seg3 top");
    op(1'b1, 1'b1, 16'h0001, 1'b1, 16'h4000, 2'b01, 1'b1, "R6 set wins over clear");
    op(1'b1, 1'b1, 16'h000F, 1'b0, 0, 2'b11, 1'b1, "R6 clear all again");
    wperm(16'hD777, "R3 info select reset, no write");
    acc(16'h19FF, 2'b01, 1'b1, "R8 reset request pulse");
    wperm(16'h0000, "R9 restore, write discarded");
    idle(1'b1, "R8 pulse ended");
    acc(16'h19FF, 2'b01, 1'b1, "R9 info write allowed after restore");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule